// File: doc/BRIEF.md
# Hit time estimator

The estimator takes six consecutive amplitude samples of one shaped detector pulse, spaced 25 ns apart, and returns the time of the hit relative to the first sample. It looks for the adjacent triplet of samples centred on the pulse peak. Where that triplet sits gives a coarse step of 0, 25, 50 or 75 ns. A fine sub-step comes from a fixed table. That table is indexed by the quantised difference of the two outer triplet samples divided by the centre sample. One table serves all four coarse positions.

Some hits cannot be timed reliably. These are hits with several separate maxima, a peak on the first or last sample, or a peak too narrow for the expected shaping curve. Such hits are flagged with a reason code, and all six raw samples are handed on for offline processing. The block is fully pipelined: it accepts one hit per clock, and every result leaves after a fixed three-cycle latency together with the hit's tag. The pipeline registers load on every clock, so outputs other than `valid_o` carry meaning only while `valid_o` is high.

Top module: `hit_time_est`

## Requirements
- R1: A hit presented with `valid_i` high at rising edge k comes out with `valid_o` high after rising edge k+3, carrying the same `tag_i`. Hits may arrive on every clock.
- R2: Sample n sits in `samples_i[10n+9:10n]`, with sample 0 the earliest. The centre is the lowest index c in 1..4 whose sample equals the maximum of all six. `time_o[3:2]` = c-1, meaning a coarse time of 25·(c-1) ns.
- R3: Let l, m and r be the samples at c-1, c and c+1. With q = floor(|r-l|·16/m), the fine index is 16+q when r ≥ l and 16-q otherwise, clamped to 0..31.
- R4: The fine sub-step `time_o[1:0]` is 0 for index 0..9, 1 for 10..15, 2 for 16..21 and 3 for 22..31.
- R5: The hit gets reason 1 (multiple maxima) when more than two samples equal the maximum, or when exactly two do and they are not adjacent.
- R6: Otherwise, the hit gets reason 2 (edge peak) when no index in 1..4 holds the maximum.
- R7: Otherwise, the hit gets reason 3 (shape mismatch) when 4·min(l, r) < m.
- R8: A hit with a nonzero reason drives `ambig_o` = 1, `time_o` = 0 and `samples_o` = its six input samples. Reason priority is R5, then R6, then R7.
- R9: A hit that passes all the tests drives `reason_o` = 0, `ambig_o` = 0 and `samples_o` = 0.
- R10: While `rst_ni` is low, `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input hit valid |
| samples_i | input | 60 | Six 10-bit amplitudes, sample 0 in the low bits |
| tag_i | input | 8 | Hit tag carried with the result |
| valid_o | output | 1 | Result valid |
| tag_o | output | 8 | Tag of the result |
| time_o | output | 4 | Coarse step (3:2) and fine sub-step (1:0) |
| ambig_o | output | 1 | Hit could not be timed |
| reason_o | output | 2 | 0 ok, 1 multiple maxima, 2 edge peak, 3 shape mismatch |
| samples_o | output | 60 | Raw samples for ambiguous hits, else zero |

## Verification
Every result is due exactly three rising edges after the edge that captured its hit. When the driver pushes a hit's expected fields, it stamps the entry with that due cycle. The monitor checks the cycle count when it pops the entry, so a result that arrives early or late fails even if its values are right. Inputs are driven and outputs sampled on the falling edge. Streams of back-to-back hits with idle gaps test that results stay in order and are not lost at full rate.

// File: rtl/hte_pkg.sv
package hte_pkg;
  typedef enum logic [1:0] {
    RSN_OK    = 2'd0,
    RSN_MULTI = 2'd1,
    RSN_EDGE  = 2'd2,
    RSN_SHAPE = 2'd3
  } reason_e;
endpackage

// File: rtl/hte_peak_select.sv
module hte_peak_select
  import hte_pkg::*;
#(
  parameter int SAMP_W = 10,
  parameter int N_SAMP = 6,
  parameter int TAG_W  = 8,
  parameter int CRS_W  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [N_SAMP*SAMP_W-1:0] samples_i,
  input  logic [TAG_W-1:0]         tag_i,
  output logic                     valid_o,
  output logic [TAG_W-1:0]         tag_o,
  output logic [N_SAMP*SAMP_W-1:0] samples_o,
  output reason_e                  reason_o,
  output logic [CRS_W-1:0]         coarse_o,
  output logic [SAMP_W-1:0]        left_o,
  output logic [SAMP_W-1:0]        mid_o,
  output logic [SAMP_W-1:0]        right_o
);
  localparam int N_CTR = N_SAMP - 2;
  localparam int CNT_W = $clog2(N_SAMP + 1);

  logic [SAMP_W-1:0] smp [N_SAMP];
  logic [SAMP_W-1:0] pk_max;
  logic [N_SAMP-1:0] eq;
  logic [CNT_W-1:0]  n_eq;
  logic              adj;
  logic [N_CTR-1:0]  sel_d, sel_q;
  logic              found;
  logic [CRS_W-1:0]  ctr_d;
  logic [SAMP_W-1:0] l_d, m_d, r_d, side_min;
  logic              narrow;
  reason_e           reason_d;

  for (genvar g = 0; g < N_SAMP; g++) begin : g_unpack
    assign smp[g] = samples_i[g*SAMP_W +: SAMP_W];
    assign eq[g]  = (smp[g] == pk_max);
  end

  always_comb begin
    pk_max = '0;
    for (int k = 0; k < N_SAMP; k++) if (smp[k] > pk_max) pk_max = smp[k];
  end

  always_comb begin
    n_eq = '0;
    adj  = 1'b0;
    for (int k = 0; k < N_SAMP; k++) if (eq[k]) n_eq = n_eq + CNT_W'(1);
    for (int k = 0; k < N_SAMP - 1; k++) if (eq[k] && eq[k+1]) adj = 1'b1;
  end

  // earliest centre holding the maximum wins ties
  always_comb begin
    sel_d = '0;
    found = 1'b0;
    ctr_d = '0;
    for (int c = 1; c <= N_CTR; c++) begin
      if (eq[c] && !found) begin
        sel_d[c-1] = 1'b1;
        found      = 1'b1;
        ctr_d      = CRS_W'(c - 1);
      end
    end
  end

  always_comb begin
    l_d = '0;
    m_d = '0;
    r_d = '0;
    for (int c = 1; c <= N_CTR; c++) begin
      if (sel_d[c-1]) begin
        l_d = smp[c-1];
        m_d = smp[c];
        r_d = smp[c+1];
      end
    end
  end

  assign side_min = (l_d < r_d) ? l_d : r_d;
  assign narrow   = {side_min, 2'b00} < {2'b00, m_d};

  always_comb begin
    if (n_eq > CNT_W'(2) || (n_eq == CNT_W'(2) && !adj)) reason_d = RSN_MULTI;
    else if (!found)                                      reason_d = RSN_EDGE;
    else if (narrow)                                      reason_d = RSN_SHAPE;
    else                                                  reason_d = RSN_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      tag_o     <= '0;
      samples_o <= '0;
      reason_o  <= RSN_OK;
      coarse_o  <= '0;
      left_o    <= '0;
      mid_o     <= '0;
      right_o   <= '0;
      sel_q     <= '0;
    end else begin
      valid_o   <= valid_i;
      tag_o     <= tag_i;
      samples_o <= samples_i;
      reason_o  <= reason_d;
      coarse_o  <= ctr_d;
      left_o    <= l_d;
      mid_o     <= m_d;
      right_o   <= r_d;
      sel_q     <= sel_d;
    end
  end

  a_r2_single_centre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot0(sel_q));

  a_r6_edge_no_centre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && reason_o == RSN_EDGE) |-> (sel_q == '0));

  a_r2_centre_is_peak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && reason_o == RSN_OK) |-> (mid_o >= left_o && mid_o >= right_o));
endmodule

// File: rtl/hte_ratio_index.sv
module hte_ratio_index
  import hte_pkg::*;
#(
  parameter int SAMP_W = 10,
  parameter int N_SAMP = 6,
  parameter int TAG_W  = 8,
  parameter int CRS_W  = 2,
  parameter int IDX_W  = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [TAG_W-1:0]         tag_i,
  input  logic [N_SAMP*SAMP_W-1:0] samples_i,
  input  reason_e                  reason_i,
  input  logic [CRS_W-1:0]         coarse_i,
  input  logic [SAMP_W-1:0]        left_i,
  input  logic [SAMP_W-1:0]        mid_i,
  input  logic [SAMP_W-1:0]        right_i,
  output logic                     valid_o,
  output logic [TAG_W-1:0]         tag_o,
  output logic [N_SAMP*SAMP_W-1:0] samples_o,
  output reason_e                  reason_o,
  output logic [CRS_W-1:0]         coarse_o,
  output logic [IDX_W-1:0]         idx_o
);
  localparam int HALF    = 2 ** (IDX_W - 1);
  localparam int IDX_MAX = 2 ** IDX_W - 1;
  localparam int NUM_W   = SAMP_W + IDX_W - 1;

  logic              up;
  logic [SAMP_W-1:0] mag;
  logic [NUM_W-1:0]  num, den, quo;
  int                raw;
  logic [IDX_W-1:0]  idx_d;

  assign up  = (right_i >= left_i);
  assign mag = up ? (right_i - left_i) : (left_i - right_i);
  assign num = {mag, {(IDX_W-1){1'b0}}};
  assign den = {{(IDX_W-1){1'b0}}, mid_i};
  assign quo = (mid_i == '0) ? '0 : num / den;

  always_comb begin
    raw = up ? (HALF + int'(quo)) : (HALF - int'(quo));
    if (raw < 0)            raw = 0;
    else if (raw > IDX_MAX) raw = IDX_MAX;
    idx_d = IDX_W'(raw);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      tag_o     <= '0;
      samples_o <= '0;
      reason_o  <= RSN_OK;
      coarse_o  <= '0;
      idx_o     <= '0;
    end else begin
      valid_o   <= valid_i;
      tag_o     <= tag_i;
      samples_o <= samples_i;
      reason_o  <= reason_i;
      coarse_o  <= coarse_i;
      idx_o     <= idx_d;
    end
  end

  a_r3_later_side_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && reason_i == RSN_OK && right_i > left_i) |=> (idx_o >= IDX_W'(HALF)));

  a_r3_earlier_side_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && reason_i == RSN_OK && right_i < left_i) |=> (idx_o <= IDX_W'(HALF)));

  a_r3_symmetric_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && reason_i == RSN_OK && right_i == left_i) |=> (idx_o == IDX_W'(HALF)));
endmodule

// File: rtl/hte_fine_lut.sv
module hte_fine_lut
  import hte_pkg::*;
#(
  parameter int SAMP_W = 10,
  parameter int N_SAMP = 6,
  parameter int TAG_W  = 8,
  parameter int CRS_W  = 2,
  parameter int IDX_W  = 5,
  parameter int FINE_W = 2,
  parameter int BAND   = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [TAG_W-1:0]         tag_i,
  input  logic [N_SAMP*SAMP_W-1:0] samples_i,
  input  reason_e                  reason_i,
  input  logic [CRS_W-1:0]         coarse_i,
  input  logic [IDX_W-1:0]         idx_i,
  output logic                     valid_o,
  output logic [TAG_W-1:0]         tag_o,
  output logic [CRS_W+FINE_W-1:0]  time_o,
  output logic                     ambig_o,
  output logic [1:0]               reason_o,
  output logic [N_SAMP*SAMP_W-1:0] samples_o
);
  localparam int ENT  = 2 ** IDX_W;
  localparam int HALF = ENT / 2;

  function automatic logic [FINE_W*ENT-1:0] build_tbl();
    logic [FINE_W*ENT-1:0] t;
    int f;
    t = '0;
    for (int e = 0; e < ENT; e++) begin
      if (e < HALF - BAND)      f = 0;
      else if (e < HALF)        f = 1;
      else if (e < HALF + BAND) f = 2;
      else                      f = 3;
      t[e*FINE_W +: FINE_W] = FINE_W'(f);
    end
    return t;
  endfunction

  localparam logic [FINE_W*ENT-1:0] FINE_TBL = build_tbl();

  logic [FINE_W-1:0] fine;
  logic              ok;

  assign fine = FINE_TBL[idx_i*FINE_W +: FINE_W];
  assign ok   = (reason_i == RSN_OK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      tag_o     <= '0;
      time_o    <= '0;
      ambig_o   <= 1'b0;
      reason_o  <= '0;
      samples_o <= '0;
    end else begin
      valid_o   <= valid_i;
      tag_o     <= tag_i;
      time_o    <= ok ? {coarse_i, fine} : '0;
      ambig_o   <= !ok;
      reason_o  <= reason_i;
      samples_o <= ok ? '0 : samples_i;
    end
  end

  a_r4_low_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ok && idx_i < IDX_W'(HALF - BAND)) |=> (time_o[FINE_W-1:0] == '0));

  a_r4_high_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ok && idx_i >= IDX_W'(HALF + BAND)) |=> (time_o[FINE_W-1:0] == '1));
endmodule

// File: rtl/hit_time_est.sv
module hit_time_est
  import hte_pkg::*;
#(
  parameter int SAMP_W = 10,
  parameter int N_SAMP = 6,
  parameter int TAG_W  = 8,
  parameter int IDX_W  = 5,
  parameter int FINE_W = 2,
  parameter int BAND   = 6,
  localparam int CRS_W  = $clog2(N_SAMP - 2),
  localparam int TIME_W = CRS_W + FINE_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [N_SAMP*SAMP_W-1:0] samples_i,
  input  logic [TAG_W-1:0]         tag_i,
  output logic                     valid_o,
  output logic [TAG_W-1:0]         tag_o,
  output logic [TIME_W-1:0]        time_o,
  output logic                     ambig_o,
  output logic [1:0]               reason_o,
  output logic [N_SAMP*SAMP_W-1:0] samples_o
);
  logic                     s1_valid, s2_valid;
  logic [TAG_W-1:0]         s1_tag, s2_tag;
  logic [N_SAMP*SAMP_W-1:0] s1_smp, s2_smp;
  reason_e                  s1_rsn, s2_rsn;
  logic [CRS_W-1:0]         s1_crs, s2_crs;
  logic [SAMP_W-1:0]        s1_l, s1_m, s1_r;
  logic [IDX_W-1:0]         s2_idx;

  hte_peak_select #(
    .SAMP_W(SAMP_W), .N_SAMP(N_SAMP), .TAG_W(TAG_W), .CRS_W(CRS_W)
  ) i_peak (
    .clk_i, .rst_ni, .valid_i, .samples_i, .tag_i,
    .valid_o(s1_valid), .tag_o(s1_tag), .samples_o(s1_smp), .reason_o(s1_rsn),
    .coarse_o(s1_crs), .left_o(s1_l), .mid_o(s1_m), .right_o(s1_r)
  );

  hte_ratio_index #(
    .SAMP_W(SAMP_W), .N_SAMP(N_SAMP), .TAG_W(TAG_W), .CRS_W(CRS_W), .IDX_W(IDX_W)
  ) i_ratio (
    .clk_i, .rst_ni,
    .valid_i(s1_valid), .tag_i(s1_tag), .samples_i(s1_smp), .reason_i(s1_rsn),
    .coarse_i(s1_crs), .left_i(s1_l), .mid_i(s1_m), .right_i(s1_r),
    .valid_o(s2_valid), .tag_o(s2_tag), .samples_o(s2_smp), .reason_o(s2_rsn),
    .coarse_o(s2_crs), .idx_o(s2_idx)
  );

  hte_fine_lut #(
    .SAMP_W(SAMP_W), .N_SAMP(N_SAMP), .TAG_W(TAG_W), .CRS_W(CRS_W),
    .IDX_W(IDX_W), .FINE_W(FINE_W), .BAND(BAND)
  ) i_lut (
    .clk_i, .rst_ni,
    .valid_i(s2_valid), .tag_i(s2_tag), .samples_i(s2_smp), .reason_i(s2_rsn),
    .coarse_i(s2_crs), .idx_i(s2_idx),
    .valid_o, .tag_o, .time_o, .ambig_o, .reason_o, .samples_o
  );

  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i, 3));

  a_r1_tag_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (tag_o == $past(tag_i, 3)));

  a_r8_raw_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ambig_o) |-> (time_o == '0 && samples_o == $past(samples_i, 3)));

  a_r9_clean_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ambig_o) |-> (samples_o == '0 && reason_o == 2'd0));

  a_r10_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o);
endmodule

// File: tb/test_hit_time_est.sv
module test_hit_time_est;
  localparam int SW = 10;
  localparam int NS = 6;
  localparam int TW = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid_i = 1'b0;
  logic [NS*SW-1:0] samples_i = '0;
  logic [TW-1:0]    tag_i = '0;
  logic             valid_o;
  logic [TW-1:0]    tag_o;
  logic [3:0]       time_o;
  logic             ambig_o;
  logic [1:0]       reason_o;
  logic [NS*SW-1:0] samples_o;

  hit_time_est i_hit_time_est (
    .clk_i(clk), .rst_ni(rst_n), .valid_i, .samples_i, .tag_i,
    .valid_o, .tag_o, .time_o, .ambig_o, .reason_o, .samples_o
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [TW-1:0]    tag;
    logic [3:0]       tm;
    logic [1:0]       rsn;
    logic [NS*SW-1:0] smp;
    logic [31:0]      due;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  logic [TW-1:0] next_tag = 8'h01;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NS*SW-1:0] pk(input int a, input int b, input int c,
                                          input int d, input int e, input int f);
    return {SW'(f), SW'(e), SW'(d), SW'(c), SW'(b), SW'(a)};
  endfunction

  function automatic void model(input logic [NS*SW-1:0] s,
                                output logic [3:0] tm, output logic [1:0] rsn);
    int v[NS];
    int m, cnt, c, l, r, mn, d, qq, idx, fine;
    bit adj;
    m = 0; cnt = 0; c = -1; adj = 0; tm = '0;
    for (int k = 0; k < NS; k++) begin
      v[k] = int'(s[k*SW +: SW]);
      if (v[k] > m) m = v[k];
    end
    for (int k = 0; k < NS; k++) if (v[k] == m) cnt++;
    for (int k = 0; k < NS - 1; k++) if (v[k] == m && v[k+1] == m) adj = 1;
    for (int k = NS - 2; k >= 1; k--) if (v[k] == m) c = k;
    if (cnt > 2 || (cnt == 2 && !adj)) rsn = 2'd1;
    else if (c < 0) rsn = 2'd2;
    else begin
      l = v[c-1]; r = v[c+1];
      mn = (l < r) ? l : r;
      if (mn * 4 < m) rsn = 2'd3;
      else begin
        rsn = 2'd0;
        d = r - l;
        qq = ((d < 0) ? -d : d) * 16 / m;
        idx = (d >= 0) ? 16 + qq : 16 - qq;
        if (idx < 0) idx = 0;
        if (idx > 31) idx = 31;
        if (idx < 10) fine = 0;
        else if (idx < 16) fine = 1;
        else if (idx < 22) fine = 2;
        else fine = 3;
        tm = 4'((c - 1) * 4 + fine);
      end
    end
  endfunction

  task automatic send(input logic [NS*SW-1:0] s);
    exp_t e;
    @(negedge clk);
    valid_i   = 1'b1;
    samples_i = s;
    tag_i     = next_tag;
    e.tag = next_tag;
    e.smp = s;
    e.due = 32'(cyc + 3);
    model(s, e.tm, e.rsn);
    if (e.rsn != 2'd0) begin
      e.tm = '0;
    end else begin
      e.smp = '0;
    end
    q.push_back(e);
    next_tag = next_tag + 8'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      samples_i = '0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (q.size() == 0) begin
        chk(1'b0, "R1", "unexpected result", 64'(tag_o), 64'h0);
      end else begin
        exp_t e;
        string rq;
        e = q.pop_front();
        chk(cyc == int'(e.due), "R1", "latency", 64'(cyc), 64'(e.due));
        chk(tag_o == e.tag, "R1", "tag", 64'(tag_o), 64'(e.tag));
        case (e.rsn)
          2'd1: rq = "R5";
          2'd2: rq = "R6";
          2'd3: rq = "R7";
          default: rq = "R9";
        endcase
        chk(reason_o == e.rsn, rq, "reason", 64'(reason_o), 64'(e.rsn));
        chk(ambig_o == (e.rsn != 2'd0), "R8", "ambig", 64'(ambig_o), 64'(e.rsn != 2'd0));
        chk(time_o[3:2] == e.tm[3:2], "R2", "coarse", 64'(time_o[3:2]), 64'(e.tm[3:2]));
        chk(time_o[1:0] == e.tm[1:0], "R3/R4", "fine", 64'(time_o[1:0]), 64'(e.tm[1:0]));
        chk(samples_o == e.smp, (e.rsn != 2'd0) ? "R8" : "R9", "samples",
            64'(samples_o), 64'(e.smp));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c, m, l, r;
    logic [NS*SW-1:0] s;
    int v[NS];
    // R10: reset holds outputs quiet
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(valid_o == 1'b0, "R10", "valid in reset", 64'(valid_o), 64'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    chk(valid_o == 1'b0, "R10", "valid after reset", 64'(valid_o), 64'h0);

    // R2: one clean peak at each centre position
    send(pk(300, 700, 400, 90, 20, 5));
    send(pk(100, 300, 500, 400, 200, 50));
    send(pk(20, 80, 400, 900, 600, 100));
    send(pk(5, 10, 60, 500, 800, 300));
    // R2 tie: earliest adjacent centre, also at the window start and end
    send(pk(100, 300, 700, 700, 300, 100));
    send(pk(700, 700, 300, 100, 50, 20));
    send(pk(20, 50, 100, 300, 700, 700));
    idle(3);
    // R3/R4: fine index around band edges
    send(pk(10, 700, 800, 400, 20, 5));
    send(pk(10, 750, 800, 400, 20, 5));
    send(pk(10, 699, 800, 400, 20, 5));
    send(pk(10, 200, 800, 200, 20, 5));
    send(pk(10, 200, 800, 800, 20, 5));
    send(pk(10, 400, 800, 700, 20, 5));
    // R5: separated maxima, three equal, all zero, and over an edge peak
    send(pk(100, 800, 200, 800, 100, 50));
    send(pk(500, 500, 500, 100, 50, 20));
    send(pk(0, 0, 0, 0, 0, 0));
    send(pk(900, 100, 900, 50, 20, 10));
    // R6: peak on first or last sample
    send(pk(900, 500, 300, 200, 100, 50));
    send(pk(50, 100, 200, 300, 500, 900));
    // R7: narrow peak, and the exact boundary that still passes
    send(pk(10, 50, 800, 100, 20, 5));
    send(pk(10, 200, 800, 199, 20, 5));
    send(pk(10, 200, 800, 200, 20, 5));
    idle(4);

    // R1: streamed pulses with gaps
    for (int i = 0; i < 400; i++) begin
      if (i % 4 == 3) begin
        for (int k = 0; k < NS; k++) v[k] = int'($urandom % 1024);
      end else begin
        c = 1 + int'($urandom % 4);
        m = 300 + int'($urandom % 700);
        l = m / 4 + int'($urandom % (m - m / 4 + 1));
        r = m / 4 + int'($urandom % (m - m / 4 + 1));
        for (int k = 0; k < NS; k++) v[k] = int'($urandom % (m / 4));
        v[c-1] = l; v[c] = m; v[c+1] = r;
      end
      s = pk(v[0], v[1], v[2], v[3], v[4], v[5]);
      send(s);
      if (i % 7 == 0) idle(1 + i % 3);
    end
    idle(8);
    chk(q.size() == 0, "R1", "pending results", 64'(q.size()), 64'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule